// File: doc/BRIEF.md
# UART Automatic Hardware Handshake

This block holds the hardware handshake logic for one UART channel. On the transmit side it decides whether the shifter may begin the next character. The decision uses the clear-to-send input, which first passes through a synchronizer. A character that has already begun runs to its end, whatever clear-to-send does while it is in flight.

On the receive side the block drives the request-to-send output from the receive FIFO fill count. It uses a halt point and a resume point with hysteresis between them. Each side has its own enable. With its enable off, the receive side hands the output to a software modem-control bit, and the transmit side always grants permission.

A transmitter asserts `tx_req` while it has a character waiting. It starts shifting in a cycle where `tx_go` is high, and it pulses `tx_done` when the stop bit ends. Both handshake pins are active low.

Top module: `uart_hwflow`

## Requirements
- R1: After reset, `rts_n` is 1, `tx_active` is 0, `tx_go` is 0 and `lvl_err` is 0. The synchronizer also starts with clear-to-send inactive.
- R2: `ext_feat[7]` enables automatic clear-to-send gating and `ext_feat[6]` enables automatic request-to-send. Bits 5..0 have no effect on any output.
- R3: When automatic clear-to-send is on, `tx_permit` is 1 exactly when the value of `cts_n` sampled two clock edges earlier was 0.
- R4: When automatic clear-to-send is off, `tx_permit` is 1 at all times.
- R5: `tx_go` is `tx_req` AND `tx_permit` AND NOT `tx_active`. `tx_go` sets `tx_active` at the next edge. `tx_active` stays 1 until an edge at which `tx_done` is 1, whatever `cts_n` does in the meantime.
- R6: When automatic request-to-send is on, an edge at which `rx_count` is at or above 4 × halt level sets `rts_n` to 1.
- R7: When automatic request-to-send is on, an edge at which `rx_count` is at or below 4 × resume level sets `rts_n` to 0. Between the two points, `rts_n` keeps its previous value.
- R8: The halt level is `ctrl_levels[3:0]` and the resume level is `ctrl_levels[7:4]`. Both are unsigned.
- R9: `lvl_err` is 1 when automatic request-to-send is on and the halt level is not greater than the resume level. While it is 1, the following edge sets `rts_n` to 1.
- R10: When automatic request-to-send is off, each edge loads `rts_n` with NOT `mcr_rts_req`.
- R11: With both enables on and `rts_n` looped to `cts_n`, no new character starts once the FIFO has reached the halt point. Starts resume after the count falls to the resume point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_feat | input | 8 | Feature bits: bit 7 is auto clear-to-send, bit 6 is auto request-to-send |
| ctrl_levels | input | 8 | Bits 3:0 are the halt level, bits 7:4 the resume level, each in units of 4 entries |
| mcr_rts_req | input | 1 | Software request-to-send, used when auto request-to-send is off |
| rx_count | input | CNT_W | Receive FIFO fill count |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_req | input | 1 | Transmitter has a character waiting |
| tx_done | input | 1 | Pulse: the character in flight has finished |
| tx_permit | output | 1 | Transmission is currently allowed |
| tx_go | output | 1 | Start the next character in this cycle |
| tx_active | output | 1 | A character is in flight |
| rts_n | output | 1 | Request-to-send pin, active low, registered |
| lvl_err | output | 1 | Halt level not above resume level |

## Verification
A character boundary can coincide with a change of clear-to-send. A `tx_done` pulse, a waiting `tx_req` and a `cts_n` edge that reaches the synchronizer output can all fall in the same cycle. The receive-side halt or resume crossing can also land in that cycle. The bench provokes these cases with a long stretch of random stimulus and with a loop from `rts_n` to `cts_n`. A behavioural model judges every clock: it decides whether a start is due in that very cycle or only after the character in flight has finished, and it decides whether the hysteresis state moves.

// File: rtl/hwf_pkg.sv
package hwf_pkg;
  localparam int LVL_W  = 4;
  localparam int WIDE_W = 16;
  localparam int AUTO_CTS_BIT = 7;
  localparam int AUTO_RTS_BIT = 6;

  typedef struct packed {
    logic auto_cts;
    logic auto_rts;
  } hwf_en_t;

  typedef struct packed {
    logic [LVL_W-1:0] resume;
    logic [LVL_W-1:0] halt;
  } hwf_lvl_t;

  function automatic hwf_en_t decode_en(input logic [7:0] feat);
    hwf_en_t e;
    e.auto_cts = feat[AUTO_CTS_BIT];
    e.auto_rts = feat[AUTO_RTS_BIT];
    return e;
  endfunction

  function automatic logic [WIDE_W-1:0] lvl_scale(input logic [LVL_W-1:0] lvl,
                                                  input int unsigned shift);
    return WIDE_W'(lvl) << shift;
  endfunction

  function automatic logic levels_bad(input logic [LVL_W-1:0] halt,
                                      input logic [LVL_W-1:0] resume);
    return !(halt > resume);
  endfunction
endpackage

// File: rtl/hwf_cts_sync.sv
module hwf_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= d_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/hwf_tx_gate.sv
module hwf_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_cts,
  input  logic cts_n_s,
  input  logic tx_req,
  input  logic tx_done,
  output logic tx_permit,
  output logic tx_go,
  output logic tx_active
);
  logic busy_q;

  assign tx_permit = !auto_cts || !cts_n_s;
  assign tx_go     = tx_req && tx_permit && !busy_q;
  assign tx_active = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_q <= 1'b0;
    else if (busy_q && tx_done) busy_q <= 1'b0;
    else if (tx_go)            busy_q <= 1'b1;
  end
endmodule

// File: rtl/hwf_rts_ctrl.sv
module hwf_rts_ctrl
  import hwf_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int SCALE_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_rts,
  input  hwf_lvl_t         levels,
  input  logic             mcr_rts_req,
  input  logic [CNT_W-1:0] rx_count,
  output logic             rts_n,
  output logic             lvl_err,
  output logic             hit_halt,
  output logic             hit_resume
);
  logic [WIDE_W-1:0] halt_pt, resume_pt, cnt_w;
  logic flow_q, flow_d, rts_n_q;

  assign halt_pt    = lvl_scale(levels.halt, SCALE_SHIFT);
  assign resume_pt  = lvl_scale(levels.resume, SCALE_SHIFT);
  assign cnt_w      = WIDE_W'(rx_count);
  assign hit_halt   = cnt_w >= halt_pt;
  assign hit_resume = cnt_w <= resume_pt;
  assign lvl_err    = auto_rts && levels_bad(levels.halt, levels.resume);

  always_comb begin
    flow_d = flow_q;
    if (lvl_err || hit_halt) flow_d = 1'b0;
    else if (hit_resume)     flow_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flow_q  <= 1'b0;
      rts_n_q <= 1'b1;
    end else begin
      flow_q  <= flow_d;
      rts_n_q <= auto_rts ? !flow_d : !mcr_rts_req;
    end
  end

  assign rts_n = rts_n_q;
endmodule

// File: rtl/uart_hwflow.sv
module uart_hwflow
  import hwf_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int SCALE_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ext_feat,
  input  logic [7:0]       ctrl_levels,
  input  logic             mcr_rts_req,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             cts_n,
  input  logic             tx_req,
  input  logic             tx_done,
  output logic             tx_permit,
  output logic             tx_go,
  output logic             tx_active,
  output logic             rts_n,
  output logic             lvl_err
);
  hwf_en_t  en;
  hwf_lvl_t lv;
  logic     cts_n_s;
  logic     hit_halt, hit_resume;

  assign en = decode_en(ext_feat);
  assign lv = hwf_lvl_t'(ctrl_levels);

  hwf_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(cts_n), .q_out(cts_n_s)
  );

  hwf_tx_gate u_tx (
    .clk(clk), .rst_n(rst_n), .auto_cts(en.auto_cts), .cts_n_s(cts_n_s),
    .tx_req(tx_req), .tx_done(tx_done), .tx_permit(tx_permit),
    .tx_go(tx_go), .tx_active(tx_active)
  );

  hwf_rts_ctrl #(.CNT_W(CNT_W), .SCALE_SHIFT(SCALE_SHIFT)) u_rts (
    .clk(clk), .rst_n(rst_n), .auto_rts(en.auto_rts), .levels(lv),
    .mcr_rts_req(mcr_rts_req), .rx_count(rx_count), .rts_n(rts_n),
    .lvl_err(lvl_err), .hit_halt(hit_halt), .hit_resume(hit_resume)
  );
endmodule

// File: rtl/hwf_checker.sv
module hwf_checker
  import hwf_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int SCALE_SHIFT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       ext_feat,
  input logic [7:0]       ctrl_levels,
  input logic             mcr_rts_req,
  input logic [CNT_W-1:0] rx_count,
  input logic             tx_req,
  input logic             tx_done,
  input logic             tx_permit,
  input logic             tx_go,
  input logic             tx_active,
  input logic             rts_n,
  input logic             lvl_err
);
  logic over_halt;
  assign over_halt = WIDE_W'(rx_count) >= lvl_scale(ctrl_levels[3:0], SCALE_SHIFT);

  a_r5_no_go_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> !tx_go);
  a_r5_flight_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !tx_done) |=> tx_active);
  a_r5_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> tx_active);
  a_r4_permit_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_feat[7] |-> tx_permit);
  a_r9_err_holds_rts: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_err |=> rts_n);
  a_r6_halt_point: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_feat[6] && over_halt) |=> rts_n);
  a_r10_manual_rts: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_feat[6] |=> (rts_n == !$past(mcr_rts_req)));
endmodule

bind uart_hwflow hwf_checker #(.CNT_W(CNT_W), .SCALE_SHIFT(SCALE_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_feat(ext_feat), .ctrl_levels(ctrl_levels),
  .mcr_rts_req(mcr_rts_req), .rx_count(rx_count), .tx_req(tx_req),
  .tx_done(tx_done), .tx_permit(tx_permit), .tx_go(tx_go),
  .tx_active(tx_active), .rts_n(rts_n), .lvl_err(lvl_err)
);

// File: tb/tb_uart_hwflow.sv
module tb_uart_hwflow;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ext_feat = 8'h00;
  logic [7:0] ctrl_levels = 8'h00;
  logic mcr_rts_req = 1'b0;
  logic [6:0] rx_count = 7'd0;
  logic cts_drv = 1'b1;
  logic loop_on = 1'b0;
  logic tx_req = 1'b0;
  logic tx_done = 1'b0;
  logic cts_n;
  logic tx_permit, tx_go, tx_active, rts_n, lvl_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int go_cnt = 0;

  int m_s1, m_s2, m_busy, m_flow, m_rts;

  always #5 clk = ~clk;

  assign cts_n = loop_on ? rts_n : cts_drv;

  uart_hwflow dut (
    .clk(clk), .rst_n(rst_n), .ext_feat(ext_feat), .ctrl_levels(ctrl_levels),
    .mcr_rts_req(mcr_rts_req), .rx_count(rx_count), .cts_n(cts_n),
    .tx_req(tx_req), .tx_done(tx_done), .tx_permit(tx_permit), .tx_go(tx_go),
    .tx_active(tx_active), .rts_n(rts_n), .lvl_err(lvl_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Reference model: compared then advanced at each falling edge.
  always @(negedge clk) begin
    int acts, arts, halt_l, res_l, e_permit, e_go, e_err;
    cyc++;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_busy = 0; m_flow = 0; m_rts = 1;
    end else begin
      acts   = ext_feat[7];
      arts   = ext_feat[6];
      halt_l = ctrl_levels[3:0];
      res_l  = ctrl_levels[7:4];
      e_permit = (acts == 0 || m_s2 == 0) ? 1 : 0;
      e_go     = (tx_req && m_busy == 0 && e_permit == 1) ? 1 : 0;
      e_err    = (arts == 1 && halt_l <= res_l) ? 1 : 0;
      chk(tx_permit == e_permit, "R2/R3/R4 tx_permit", tx_permit, e_permit);
      chk(tx_go == e_go, "R5 tx_go", tx_go, e_go);
      chk(tx_active == m_busy, "R5 tx_active", tx_active, m_busy);
      chk(rts_n == m_rts, "R6/R7/R9/R10 rts_n", rts_n, m_rts);
      chk(lvl_err == e_err, "R9 lvl_err", lvl_err, e_err);
      if (tx_go) go_cnt++;
      m_s2 = m_s1;
      m_s1 = cts_n;
      if (m_busy == 1 && tx_done) m_busy = 0;
      else if (e_go == 1) m_busy = 1;
      if (e_err == 1) m_flow = 0;
      else if (rx_count >= halt_l * 4) m_flow = 0;
      else if (rx_count <= res_l * 4) m_flow = 1;
      m_rts = (arts == 1) ? 1 - m_flow : (mcr_rts_req ? 0 : 1);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 150000; wd++) @(posedge clk);
    chk(0, "watchdog", wd, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rts_n == 1'b1, "R1 rts_n", rts_n, 1);
    chk(tx_active == 1'b0, "R1 tx_active", tx_active, 0);
    chk(tx_go == 1'b0, "R1 tx_go", tx_go, 0);
    chk(lvl_err == 1'b0, "R1 lvl_err", lvl_err, 0);
    step(1);

    // R10 software-driven request-to-send
    mcr_rts_req = 1'b1; step(1);
    @(negedge clk); chk(rts_n == 1'b0, "R10 manual assert", rts_n, 0);
    step(1); mcr_rts_req = 1'b0; step(1);
    @(negedge clk); chk(rts_n == 1'b1, "R10 manual release", rts_n, 1);

    // R2 low feature bits ignored
    step(1); ext_feat = 8'h3F; cts_drv = 1'b1; tx_req = 1'b1;
    @(negedge clk); chk(tx_go == 1'b1, "R2 low bits ignored", tx_go, 1);
    step(1); tx_req = 1'b0; tx_done = 1'b1; step(1); tx_done = 1'b0;

    // R3 and R5: auto clear-to-send, character not cut off
    ext_feat = 8'h80; cts_drv = 1'b0; step(3);
    @(negedge clk); chk(tx_permit == 1'b1, "R3 permit after sync", tx_permit, 1);
    step(1); tx_req = 1'b1; step(1); tx_req = 1'b0; cts_drv = 1'b1;
    step(1);
    @(negedge clk); chk(tx_permit == 1'b1, "R3 one edge not enough", tx_permit, 1);
    step(1);
    @(negedge clk); chk(tx_permit == 1'b0, "R3 two edges", tx_permit, 0);
    step(4);
    @(negedge clk); chk(tx_active == 1'b1, "R5 char kept in flight", tx_active, 1);
    step(1); tx_done = 1'b1; tx_req = 1'b1; step(1); tx_done = 1'b0;
    @(negedge clk); chk(tx_go == 1'b0, "R5 blocked by CTS", tx_go, 0);
    step(1); tx_req = 1'b0;

    // R6, R7, R8 hysteresis: halt level 8 (32), resume level 4 (16)
    ext_feat = 8'h40; ctrl_levels = 8'h48; rx_count = 7'd0; step(2);
    @(negedge clk); chk(rts_n == 1'b0, "R7 resumed at zero", rts_n, 0);
    step(1); rx_count = 7'd31; step(2);
    @(negedge clk); chk(rts_n == 1'b0, "R8 below halt", rts_n, 0);
    step(1); rx_count = 7'd32; step(1);
    @(negedge clk); chk(rts_n == 1'b1, "R6 halt at 32", rts_n, 1);
    step(1); rx_count = 7'd17; step(2);
    @(negedge clk); chk(rts_n == 1'b1, "R7 hysteresis hold", rts_n, 1);
    step(1); rx_count = 7'd16; step(1);
    @(negedge clk); chk(rts_n == 1'b0, "R7 resume at 16", rts_n, 0);

    // R9 level error
    step(1); ctrl_levels = 8'h55; step(1);
    @(negedge clk);
    chk(lvl_err == 1'b1, "R9 error flag", lvl_err, 1);
    chk(rts_n == 1'b1, "R9 rts held", rts_n, 1);

    // R11 loopback
    step(1); ctrl_levels = 8'h48; ext_feat = 8'hC0; loop_on = 1'b1;
    rx_count = 7'd40; step(6);
    go_cnt = 0; tx_req = 1'b1; step(10);
    @(negedge clk); chk(go_cnt == 0, "R11 no start at halt", go_cnt, 0);
    step(1); rx_count = 7'd0; step(6);
    @(negedge clk); chk(go_cnt > 0, "R11 starts resume", go_cnt, 1);
    step(1); tx_req = 1'b0; tx_done = 1'b1; step(1); tx_done = 1'b0; loop_on = 1'b0;

    // Random phase: coinciding boundaries, CTS edges and level crossings
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 2) ext_feat = 8'(($urandom_range(0, 3) << 6) | $urandom_range(0, 63));
      if (r >= 2 && r < 4) ctrl_levels = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 9) == 0) cts_drv = ~cts_drv;
      if ($urandom_range(0, 3) == 0) begin
        if ($urandom_range(0, 1) == 1 && rx_count < 7'd64) rx_count = rx_count + 7'd3;
        else if (rx_count > 7'd2) rx_count = rx_count - 7'd3;
      end
      loop_on = (i > 2000 && i < 3000);
      mcr_rts_req = 1'($urandom_range(0, 1));
      tx_req = ($urandom_range(0, 2) != 0);
      tx_done = ($urandom_range(0, 4) == 0);
      step(1);
    end
    step(2);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule